// File: doc/BRIEF.md
# Configuration-Done Ready Sequencer

This block decides when a freshly configured device may hand its pins over to the user design. Once the loader reports that the configuration image is in place, the sequencer either raises `ready` at once, when integrity checking is switched off, or first launches exactly one full verification pass of the configuration memory and raises `ready` only if that pass ends clean. User I/O release (`io_enable`) rises on the same clock edge as `ready`. A pass that reports an uncorrectable error leaves `ready` low and records the failure in two status registers. These are a sticky failure flag and the number of clock edges the failing pass took.

Integrity checking starts off after power-on reset. A single-bit register, written through a write strobe, turns it on or off. The bit is sampled only when a pass would be launched, so a write made while a pass is running applies to the next launch. An external active-low reset pin is synchronised and qualified. Only a low level held for at least `MIN_LOW_CYC` clock cycles (50 by default) produces a restart request when the pin is released. That request sends the sequencer back to waiting for a new load and clears the error status. Shorter low pulses are dropped.

Top module: `cfg_ready_seq`

## Requirements
- R1: After power-on reset `ready`, `io_enable`, `start_pass`, `restart_config`, `err_flag` and `err_cycles` are all 0, and integrity checking is disabled.
- R2: With checking disabled, a `load_done` sampled while waiting for a load makes `ready` 1 from the next cycle, and no `start_pass` pulse occurs.
- R3: `io_enable` equals `ready` in every cycle.
- R4: With checking enabled, a `load_done` sampled while waiting for a load produces a `start_pass` pulse exactly one cycle wide in the next cycle, and `ready` stays 0 while the pass runs.
- R5: A `pass_done` with `pass_uncorr` = 0 sampled during the pass makes `ready` 1 from the next cycle.
- R6: A `pass_done` with `pass_uncorr` = 1 sampled during the pass keeps `ready` at 0, sets `err_flag` to 1 and loads `err_cycles` with the number of rising edges from the launch edge to the reporting edge (saturating at 2^STAMP_W-1). This state holds until a qualified restart.
- R7: A write (`cfg_wr` = 1) stores `cfg_wdata` as the check-enable bit (1 = enabled). A write during a running pass does not change that pass and takes effect at the next launch.
- R8: When `cfg_rst_n` has been low for at least MIN_LOW_CYC cycles and then goes high, `restart_config` pulses for exactly one cycle within SYNC_STAGES+2 cycles of the release. On the next cycle `ready` and `err_flag` are 0 and `err_cycles` is 0, and the sequencer again waits for `load_done`.
- R9: A `cfg_rst_n` low pulse shorter than MIN_LOW_CYC cycles produces no `restart_config` pulse, and `ready`, `err_flag` and `err_cycles` keep their values.
- R10: `load_done` is ignored unless the sequencer is waiting for a load. While `ready` is high or a pass is running, it causes no `start_pass` and no change of `ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| por_n | input | 1 | Power-on reset for the block, active low, asynchronous |
| cfg_rst_n | input | 1 | External reconfiguration reset pin, active low, asynchronous to clk |
| load_done | input | 1 | Loader reports the configuration image is complete |
| cfg_wr | input | 1 | Write strobe for the check-enable bit |
| cfg_wdata | input | 1 | Value written to the check-enable bit (1 = enable) |
| pass_done | input | 1 | Verification pass has finished |
| pass_uncorr | input | 1 | Qualifies `pass_done`: the pass found an uncorrectable error |
| start_pass | output | 1 | One-cycle launch pulse for the verification pass |
| ready | output | 1 | Configuration complete and verified |
| io_enable | output | 1 | User I/O release |
| err_flag | output | 1 | Sticky uncorrectable-error status |
| err_cycles | output | STAMP_W | Length in cycles of the failing pass |
| restart_config | output | 1 | One-cycle request to restart the configuration engine |

## Verification
A corrupted sequencer state shows at the ports one cycle after the edge that causes it. In that cycle either `ready`/`io_enable` rises without a launch or clean completion, or a second `start_pass` appears. A broken low-time counter in the reset qualifier shows up only on release of the pin. There, a 49-cycle pulse that produces `restart_config`, or a 50-cycle pulse that does not, tells the two apart within SYNC_STAGES+2 cycles. A wrong pass-length counter is visible only after an uncorrectable report, as an `err_cycles` value that differs from the number of edges the bench spent between launch and report.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

  typedef enum logic [1:0] {
    ST_WAIT_LOAD = 2'd0,
    ST_CHECKING  = 2'd1,
    ST_RELEASED  = 2'd2,
    ST_FAILED    = 2'd3
  } seq_state_e;

  // Saturating increment used by both counters in the block.
  function automatic logic [31:0] sat_inc(input logic [31:0] val,
                                          input logic [31:0] lim);
    return (val >= lim) ? lim : val + 32'd1;
  endfunction

  // True once a low level has lasted long enough to count as a reset request.
  function automatic logic low_long_enough(input logic [31:0] low_cnt,
                                           input logic [31:0] min_low);
    return low_cnt >= min_low;
  endfunction

endpackage

// File: rtl/cfg_rst_qual.sv
module cfg_rst_qual #(
  parameter int MIN_LOW_CYC = 50,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic pin_n,
  output logic qual_ok,
  output logic restart_q
);
  import cfg_seq_pkg::*;

  localparam int LOW_W = $clog2(MIN_LOW_CYC + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   pin_low;
  logic [LOW_W-1:0]       low_cnt;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) sync_q <= 1'b1;
        else        sync_q <= pin_n;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
      end
    end
  endgenerate

  assign pin_low = !sync_q[SYNC_STAGES-1];
  assign qual_ok = low_long_enough(32'(low_cnt), 32'(MIN_LOW_CYC));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      low_cnt   <= '0;
      restart_q <= 1'b0;
    end else begin
      restart_q <= !pin_low && qual_ok;
      if (pin_low) low_cnt <= LOW_W'(sat_inc(32'(low_cnt), 32'(MIN_LOW_CYC)));
      else         low_cnt <= '0;
    end
  end

endmodule

// File: rtl/cfg_seq_fsm.sv
module cfg_seq_fsm (
  input  logic clk,
  input  logic por_n,
  input  logic restart,
  input  logic load_done,
  input  logic chk_en,
  input  logic pass_done,
  input  logic pass_uncorr,
  output logic launch_evt,
  output logic fail_evt,
  output logic in_check,
  output logic start_pass,
  output logic ready,
  output logic io_enable
);
  import cfg_seq_pkg::*;

  seq_state_e st_q, st_d;

  always_comb begin
    st_d       = st_q;
    launch_evt = 1'b0;
    fail_evt   = 1'b0;
    if (restart) begin
      st_d = ST_WAIT_LOAD;
    end else begin
      case (st_q)
        ST_WAIT_LOAD: if (load_done) begin
          if (chk_en) begin
            launch_evt = 1'b1;
            st_d       = ST_CHECKING;
          end else begin
            st_d = ST_RELEASED;
          end
        end
        ST_CHECKING: if (pass_done) begin
          if (pass_uncorr) begin
            fail_evt = 1'b1;
            st_d     = ST_FAILED;
          end else begin
            st_d = ST_RELEASED;
          end
        end
        default: st_d = st_q;
      endcase
    end
  end

  assign in_check = (st_q == ST_CHECKING);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st_q       <= ST_WAIT_LOAD;
      start_pass <= 1'b0;
      ready      <= 1'b0;
      io_enable  <= 1'b0;
    end else begin
      st_q       <= st_d;
      start_pass <= launch_evt;
      ready      <= (st_d == ST_RELEASED);
      io_enable  <= (st_d == ST_RELEASED);
    end
  end

endmodule

// File: rtl/cfg_err_capture.sv
module cfg_err_capture #(
  parameter int STAMP_W = 16
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               clear,
  input  logic               launch,
  input  logic               in_check,
  input  logic               fail,
  output logic               err_flag,
  output logic [STAMP_W-1:0] err_cycles
);
  import cfg_seq_pkg::*;

  localparam logic [31:0] STAMP_MAX = 32'((64'd1 << STAMP_W) - 64'd1);

  logic [STAMP_W-1:0] run_cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      run_cnt    <= '0;
      err_flag   <= 1'b0;
      err_cycles <= '0;
    end else begin
      if (launch)        run_cnt <= '0;
      else if (in_check) run_cnt <= STAMP_W'(sat_inc(32'(run_cnt), STAMP_MAX));
      if (clear) begin
        err_flag   <= 1'b0;
        err_cycles <= '0;
      end else if (fail) begin
        err_flag   <= 1'b1;
        err_cycles <= STAMP_W'(sat_inc(32'(run_cnt), STAMP_MAX));
      end
    end
  end

endmodule

// File: rtl/cfg_ready_seq.sv
module cfg_ready_seq #(
  parameter int MIN_LOW_CYC = 50,
  parameter int SYNC_STAGES = 2,
  parameter int STAMP_W     = 16
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               cfg_rst_n,
  input  logic               load_done,
  input  logic               cfg_wr,
  input  logic               cfg_wdata,
  input  logic               pass_done,
  input  logic               pass_uncorr,
  output logic               start_pass,
  output logic               ready,
  output logic               io_enable,
  output logic               err_flag,
  output logic [STAMP_W-1:0] err_cycles,
  output logic               restart_config
);

  logic chk_en_q;
  logic qual_ok;
  logic launch_evt;
  logic fail_evt;
  logic in_check;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      chk_en_q <= 1'b0;
    else if (cfg_wr) chk_en_q <= cfg_wdata;
  end

  cfg_rst_qual #(
    .MIN_LOW_CYC(MIN_LOW_CYC),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_qual (
    .clk      (clk),
    .por_n    (por_n),
    .pin_n    (cfg_rst_n),
    .qual_ok  (qual_ok),
    .restart_q(restart_config)
  );

  cfg_seq_fsm u_fsm (
    .clk        (clk),
    .por_n      (por_n),
    .restart    (restart_config),
    .load_done  (load_done),
    .chk_en     (chk_en_q),
    .pass_done  (pass_done),
    .pass_uncorr(pass_uncorr),
    .launch_evt (launch_evt),
    .fail_evt   (fail_evt),
    .in_check   (in_check),
    .start_pass (start_pass),
    .ready      (ready),
    .io_enable  (io_enable)
  );

  cfg_err_capture #(.STAMP_W(STAMP_W)) u_err (
    .clk       (clk),
    .por_n     (por_n),
    .clear     (restart_config),
    .launch    (launch_evt),
    .in_check  (in_check),
    .fail      (fail_evt),
    .err_flag  (err_flag),
    .err_cycles(err_cycles)
  );

endmodule

// File: rtl/cfg_ready_seq_chk.sv
module cfg_ready_seq_chk #(
  parameter int STAMP_W = 16
) (
  input logic               clk,
  input logic               por_n,
  input logic               load_done,
  input logic               pass_done,
  input logic               pass_uncorr,
  input logic               start_pass,
  input logic               ready,
  input logic               io_enable,
  input logic               err_flag,
  input logic [STAMP_W-1:0] err_cycles,
  input logic               restart_config,
  input logic               chk_en_q,
  input logic               qual_ok
);

  a_r3_io_matches_ready: assert property (@(posedge clk) disable iff (!por_n)
    io_enable == ready);

  a_r4_start_one_cycle: assert property (@(posedge clk) disable iff (!por_n)
    start_pass |=> !start_pass);

  a_r4_start_not_ready: assert property (@(posedge clk) disable iff (!por_n)
    start_pass |-> !ready);

  a_r2_ready_has_cause: assert property (@(posedge clk) disable iff (!por_n)
    $rose(ready) |-> ($past(load_done && !chk_en_q) || $past(pass_done && !pass_uncorr)));

  a_r6_fail_blocks_ready: assert property (@(posedge clk) disable iff (!por_n)
    err_flag |-> !ready);

  a_r6_error_sticky: assert property (@(posedge clk) disable iff (!por_n)
    (err_flag && !restart_config) |=> (err_flag && $stable(err_cycles)));

  a_r8_restart_clears: assert property (@(posedge clk) disable iff (!por_n)
    restart_config |=> (!ready && !err_flag && err_cycles == '0));

  a_r9_restart_qualified: assert property (@(posedge clk) disable iff (!por_n)
    restart_config |-> $past(qual_ok));

  a_r8_restart_single: assert property (@(posedge clk) disable iff (!por_n)
    restart_config |=> !restart_config);

endmodule

bind cfg_ready_seq cfg_ready_seq_chk #(.STAMP_W(STAMP_W)) u_chk (
  .clk           (clk),
  .por_n         (por_n),
  .load_done     (load_done),
  .pass_done     (pass_done),
  .pass_uncorr   (pass_uncorr),
  .start_pass    (start_pass),
  .ready         (ready),
  .io_enable     (io_enable),
  .err_flag      (err_flag),
  .err_cycles    (err_cycles),
  .restart_config(restart_config),
  .chk_en_q      (chk_en_q),
  .qual_ok       (qual_ok)
);

// File: tb/tb_cfg_ready_seq.sv
`timescale 1ns/1ps
module tb_cfg_ready_seq;

  localparam int MIN_LOW = 50;
  localparam int SYNC    = 2;
  localparam int SW      = 16;

  logic clk = 1'b0;
  logic por_n = 1'b0, cfg_rst_n = 1'b1, load_done = 1'b0;
  logic cfg_wr = 1'b0, cfg_wdata = 1'b0, pass_done = 1'b0, pass_uncorr = 1'b0;
  logic start_pass, ready, io_enable, err_flag, restart_config;
  logic [SW-1:0] err_cycles;

  int checks = 0;
  int errors = 0;
  int starts = 0;
  int restarts = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cfg_ready_seq #(.MIN_LOW_CYC(MIN_LOW), .SYNC_STAGES(SYNC), .STAMP_W(SW)) dut (
    .clk(clk), .por_n(por_n), .cfg_rst_n(cfg_rst_n), .load_done(load_done),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .pass_done(pass_done),
    .pass_uncorr(pass_uncorr), .start_pass(start_pass), .ready(ready),
    .io_enable(io_enable), .err_flag(err_flag), .err_cycles(err_cycles),
    .restart_config(restart_config));

  always @(posedge clk) begin
    if (start_pass) starts++;
    if (restart_config) restarts++;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_load();
    load_done = 1'b1;
    @(negedge clk);
    load_done = 1'b0;
  endtask

  task automatic write_en(input logic v);
    cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_wdata = 1'b0;
  endtask

  // Report pass end at the k-th edge after the launch edge; caller sits at the
  // negedge right after the launch edge.
  task automatic finish_pass(input int k, input logic bad);
    repeat (k - 1) @(negedge clk);
    pass_done = 1'b1; pass_uncorr = bad;
    @(negedge clk);
    pass_done = 1'b0; pass_uncorr = 1'b0;
  endtask

  task automatic hold_pin_low(input int n);
    cfg_rst_n = 1'b0;
    repeat (n) @(negedge clk);
    cfg_rst_n = 1'b1;
    repeat (SYNC + 4) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 ready", ready, 0);
    check("R1 io_enable", io_enable, 0);
    check("R1 start_pass", start_pass, 0);
    check("R1 restart_config", restart_config, 0);
    check("R1 err_flag", err_flag, 0);
    check("R1 err_cycles", int'(err_cycles), 0);
  endtask

  task automatic t_disabled_load();
    int s0 = starts;
    pulse_load();
    check("R2 ready after load (check off by default, R1)", ready, 1);
    check("R3 io_enable with ready", io_enable, 1);
    check("R2 no start_pass", starts - s0, 0);
    pulse_load();
    repeat (3) @(negedge clk);
    check("R10 load while released: no start", starts - s0, 0);
    check("R10 load while released: ready kept", ready, 1);
  endtask

  task automatic t_short_pulse(input int exp_ready, input int exp_err, input int exp_cyc);
    int r0 = restarts;
    hold_pin_low(MIN_LOW - 1);
    check("R9 no restart on short low", restarts - r0, 0);
    check("R9 ready unchanged", ready, exp_ready);
    check("R9 err_flag unchanged", err_flag, exp_err);
    check("R9 err_cycles unchanged", int'(err_cycles), exp_cyc);
  endtask

  task automatic t_restart();
    int r0 = restarts;
    hold_pin_low(MIN_LOW);
    check("R8 one restart pulse", restarts - r0, 1);
    check("R8 ready cleared", ready, 0);
    check("R3 io_enable cleared", io_enable, 0);
    check("R8 err_flag cleared", err_flag, 0);
    check("R8 err_cycles cleared", int'(err_cycles), 0);
  endtask

  task automatic t_pass_ok();
    int s0 = starts;
    write_en(1'b1);
    pulse_load();
    check("R4 start_pass pulse", start_pass, 1);
    check("R4 ready low at launch", ready, 0);
    @(negedge clk);
    check("R4 start_pass one cycle", start_pass, 0);
    finish_pass(3, 1'b0);
    check("R5 ready after clean pass", ready, 1);
    check("R3 io_enable after clean pass", io_enable, 1);
    check("R5 err_flag clear", err_flag, 0);
    check("R4 exactly one launch", starts - s0, 1);
  endtask

  task automatic t_pass_fail();
    pulse_load();
    check("R4 launch on fail run", start_pass, 1);
    finish_pass(7, 1'b1);
    check("R6 ready stays low", ready, 0);
    check("R6 err_flag set", err_flag, 1);
    check("R6 err_cycles", int'(err_cycles), 7);
    repeat (20) @(negedge clk);
    check("R6 still failed", err_flag, 1);
    check("R6 ready still low", ready, 0);
  endtask

  task automatic t_write_during_pass();
    int s0 = starts;
    write_en(1'b1);
    pulse_load();
    write_en(1'b0);
    pulse_load();
    check("R10 load during pass ignored", starts - s0, 1);
    check("R7 pass still running", ready, 0);
    finish_pass(2, 1'b0);
    check("R7 pass finished normally", ready, 1);
    t_restart();
    s0 = starts;
    pulse_load();
    check("R7 new value used at next launch", starts - s0, 0);
    check("R7 ready without pass", ready, 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled_load();
    t_short_pulse(1, 0, 0);
    t_restart();
    t_pass_ok();
    t_restart();
    t_pass_fail();
    t_short_pulse(0, 1, 7);
    t_restart();
    t_write_during_pass();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule